// File: doc/BRIEF.md
# Multicycle Instruction Cycle Controller

This block is the control unit and a small accumulator datapath for a simple processor with a single internal bus. It steps every instruction through a fetch subcycle, an indirect subcycle when the instruction asks for one, and an execute subcycle. When an interrupt is pending and enabled, it adds an interrupt subcycle before the next fetch. Each register transfer between the program counter, the memory address register, the memory buffer register and the instruction register takes one clock.

A synchronous word memory sits outside the block. The block drives the memory address from its address register and the write data from its buffer register, and raises a read strobe or a write strobe. Read data must come back exactly one cycle after the read strobe. On interrupt entry the program counter goes onto a downward-growing stack in the same memory, and control passes to a fixed handler address. A 7-bit status word shows the result flags and the two mode bits.

Top module: `icyc_ctrl`

## Requirements
- R1: While reset (synchronous, active low) is held, `status` reads 0x40: supervisor set, interrupt enable clear, every flag clear. The first read after release fetches address 0.
- R2: Fetch takes four clocks: MAR is loaded from PC and PC increments; the read strobe is raised with `mem_addr` equal to the old PC; the returned word, valid the cycle after the strobe, is captured in MBR; MBR is copied to IR. The next fetch reads the following address.
- R3: An instruction word holds the opcode in bits [15:12], the indirect flag in bit 11 and the address field in bits [10:0]. The opcodes are 0 no-op, 1 load, 2 store, 3 add, 4 and, 5 compare, 6 jump, 7 jump-if-zero, 8 jump-if-negative, 9 enable interrupts, A disable interrupts, B leave supervisor mode. Unlisted codes act as no-ops. A memory operand is read from the effective address four cycles after the fetch read.
- R4: When bit 11 is set, an indirect subcycle reads the word at the address field. Its low 11 bits replace the address field as the effective address before execute.
- R5: Store copies the accumulator into MBR and writes it to the effective address with one write strobe.
- R6: Load sets sign and zero from the loaded word. Add sets sign, zero, carry (bit 2) and signed overflow (bit 4). And sets sign and zero. Flag bits not named for an operation keep their value. Status bits are: 0 sign, 1 zero, 2 carry, 3 equal, 4 overflow, 5 interrupt enable, 6 supervisor.
- R7: Compare sets the equal bit (bit 3) to whether the accumulator equals the operand. It leaves the accumulator and the other flags unchanged.
- R8: Jump always loads PC with the effective address. Jump-if-zero does so only when the zero bit is set, and jump-if-negative only when the sign bit is set.
- R9: Interrupt entry copies PC (the address of the next instruction) into MBR, loads MAR from the stack pointer, writes MBR to memory and decrements the stack pointer, then loads PC with `HANDLER`. The stack pointer starts at `STACK_TOP` after reset.
- R10: An interrupt is taken only when `irq` is high as an instruction finishes and interrupt enable, as that instruction leaves it, is set. Otherwise `irq` has no effect.
- R11: Interrupt entry clears interrupt enable and sets supervisor. The enable and disable instructions set and clear interrupt enable, and the leave-supervisor instruction clears supervisor.
- R12: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request, level sensitive |
| mem_rdata | input | DW (16) | Read word, valid the cycle after `mem_re` |
| mem_addr | output | AW (11) | Memory address (MAR) |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW (16) | Write word (MBR) |
| status | output | 7 | Status word, bit layout in R6 |

## Verification
The bench builds the block with the default DW of 16, AW of 11, STACK_TOP of 0x7FF and HANDLER of 0x040. Memory is therefore a 2048-word array. The stack starts at its last word, and a handler placed low in memory never overlaps the test programs. These values allow an add that sets both carry and overflow with 16-bit operands, and a second interrupt entry that shows the stack pointer stepping from 0x7FF to 0x7FE. Because an indirect pointer's low 11 bits become the effective address, one indirect store can land in the result area.

// File: rtl/icyc_pkg.sv
// Shared types for the instruction cycle controller: opcodes, sequencer
// states, the status word layout and the control bundles the sequencer
// hands to the datapath pieces.
package icyc_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'h0,
        OP_LDA = 4'h1,
        OP_STA = 4'h2,
        OP_ADD = 4'h3,
        OP_AND = 4'h4,
        OP_CMP = 4'h5,
        OP_JMP = 4'h6,
        OP_JZ  = 4'h7,
        OP_JN  = 4'h8,
        OP_EI  = 4'h9,
        OP_DI  = 4'hA,
        OP_USR = 4'hB
    } opcode_e;

    // F: fetch, I: indirect, E: execute, N: interrupt entry
    typedef enum logic [3:0] {
        S_F0, S_F1, S_F2, S_F3,
        S_I0, S_I1, S_I2, S_I3,
        S_E0, S_E1, S_E2, S_E3,
        S_N0, S_N1, S_N2, S_N3
    } state_e;

    // Packed MSB first: sup is bit 6, sign is bit 0.
    typedef struct packed {
        logic sup;
        logic ie;
        logic ovf;
        logic eq;
        logic carry;
        logic zero;
        logic sign;
    } status_t;

    // Register transfers carried out by the address/instruction registers.
    typedef struct packed {
        logic pc_to_mar;
        logic pc_inc;
        logic ea_to_mar;
        logic sp_to_mar;
        logic pc_to_ea;
        logic pc_to_handler;
        logic mem_to_mbr;
        logic ac_to_mbr;
        logic pc_to_mbr;
        logic mbr_to_ir;
        logic mbr_to_ea;
        logic sp_dec;
    } xfer_t;

    // Operations carried out by the accumulator and mode logic.
    typedef struct packed {
        logic alu_go;
        logic ie_set;
        logic ie_clr;
        logic sup_set;
        logic sup_clr;
    } exec_t;

endpackage

// File: rtl/icyc_seq.sv
// Subcycle sequencer. One state per register transfer. It walks fetch,
// the optional indirect step, execute and the optional interrupt entry,
// and emits the transfer, operation and memory strobe controls.
// Assumes memory returns read data one cycle after the read strobe.
module icyc_seq
    import icyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ir_op,
    input  logic       mbr_ind,
    input  logic       flag_zero,
    input  logic       flag_sign,
    input  logic       ie,
    input  logic       irq,
    output state_e     state,
    output xfer_t      xfer,
    output exec_t      exe,
    output logic       mem_rd,
    output logic       mem_wr
);

    state_e nxt;
    logic   rd_op;
    logic   wr_op;
    logic   taken;
    logic   done;
    logic   ie_after;

    // Decode operand class and branch outcome from the current instruction.
    always_comb begin
        rd_op = (ir_op == OP_LDA) || (ir_op == OP_ADD) ||
                (ir_op == OP_AND) || (ir_op == OP_CMP);
        wr_op = (ir_op == OP_STA);
        taken = (ir_op == OP_JMP) ||
                ((ir_op == OP_JZ) && flag_zero) ||
                ((ir_op == OP_JN) && flag_sign);
    end

    // Next state and per-state control outputs.
    always_comb begin
        xfer   = '0;
        exe    = '0;
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        done   = 1'b0;
        nxt    = state;
        unique case (state)
            S_F0: begin xfer.pc_to_mar = 1'b1; xfer.pc_inc = 1'b1; nxt = S_F1; end
            S_F1: begin mem_rd = 1'b1; nxt = S_F2; end
            S_F2: begin xfer.mem_to_mbr = 1'b1; nxt = S_F3; end
            S_F3: begin
                xfer.mbr_to_ir = 1'b1;
                nxt = mbr_ind ? S_I0 : S_E0;
            end
            S_I0: begin xfer.ea_to_mar = 1'b1; nxt = S_I1; end
            S_I1: begin mem_rd = 1'b1; nxt = S_I2; end
            S_I2: begin xfer.mem_to_mbr = 1'b1; nxt = S_I3; end
            S_I3: begin xfer.mbr_to_ea = 1'b1; nxt = S_E0; end
            S_E0: begin
                if (rd_op || wr_op) begin
                    xfer.ea_to_mar = 1'b1;
                    nxt = S_E1;
                end else begin
                    xfer.pc_to_ea = taken;
                    exe.ie_set    = (ir_op == OP_EI);
                    exe.ie_clr    = (ir_op == OP_DI);
                    exe.sup_clr   = (ir_op == OP_USR);
                    done          = 1'b1;
                end
            end
            S_E1: begin
                if (wr_op) xfer.ac_to_mbr = 1'b1;
                else       mem_rd = 1'b1;
                nxt = S_E2;
            end
            S_E2: begin
                if (wr_op) begin
                    mem_wr = 1'b1;
                    done   = 1'b1;
                end else begin
                    xfer.mem_to_mbr = 1'b1;
                    nxt = S_E3;
                end
            end
            S_E3: begin exe.alu_go = 1'b1; done = 1'b1; end
            S_N0: begin xfer.pc_to_mbr = 1'b1; nxt = S_N1; end
            S_N1: begin xfer.sp_to_mar = 1'b1; nxt = S_N2; end
            S_N2: begin mem_wr = 1'b1; xfer.sp_dec = 1'b1; nxt = S_N3; end
            S_N3: begin
                xfer.pc_to_handler = 1'b1;
                exe.ie_clr  = 1'b1;
                exe.sup_set = 1'b1;
                nxt = S_F0;
            end
            default: nxt = S_F0;
        endcase
        // Interrupt check uses the enable as the finishing instruction leaves it.
        ie_after = exe.ie_set | (ie & ~exe.ie_clr);
        if (done) nxt = (irq && ie_after) ? S_N0 : S_F0;
    end

    // State register; reset enters fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_F0;
        else        state <= nxt;
    end

    AST_STROBE_ONLY_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (state == S_F2 || state == S_I2 || state == S_E2)); // R2

endmodule

// File: rtl/icyc_regs.sv
// Address and instruction registers: PC, MAR, MBR, IR and the stack
// pointer. Applies the transfers the sequencer selects. Assumes at most
// one source per destination register is selected in any cycle.
module icyc_regs
    import icyc_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 11,
    parameter int STACK_TOP = 'h7FF,
    parameter int HANDLER   = 'h040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_t         xfer,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] ac,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir
);

    localparam int PADW = DW - AW;

    logic [AW-1:0] sp;

    // Program counter: fetch increment, branch target or handler entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pc <= '0;
        else if (xfer.pc_to_handler) pc <= AW'(HANDLER);
        else if (xfer.pc_to_ea)      pc <= ir[AW-1:0];
        else if (xfer.pc_inc)        pc <= pc + AW'(1);
    end

    // Memory address register: from PC, address field or stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n)              mar <= '0;
        else if (xfer.pc_to_mar) mar <= pc;
        else if (xfer.ea_to_mar) mar <= ir[AW-1:0];
        else if (xfer.sp_to_mar) mar <= sp;
    end

    // Memory buffer register: from memory, accumulator or PC.
    always_ff @(posedge clk) begin
        if (!rst_n)               mbr <= '0;
        else if (xfer.mem_to_mbr) mbr <= mem_rdata;
        else if (xfer.ac_to_mbr)  mbr <= ac;
        else if (xfer.pc_to_mbr)  mbr <= {{PADW{1'b0}}, pc};
    end

    // Instruction register: whole word at fetch, address field after indirect.
    always_ff @(posedge clk) begin
        if (!rst_n)              ir <= '0;
        else if (xfer.mbr_to_ir) ir <= mbr;
        else if (xfer.mbr_to_ea) ir[AW-1:0] <= mbr[AW-1:0];
    end

    // Stack pointer: steps down once per interrupt save.
    always_ff @(posedge clk) begin
        if (!rst_n)          sp <= AW'(STACK_TOP);
        else if (xfer.sp_dec) sp <= sp - AW'(1);
    end

    AST_SAVE_USES_SP: assert property (@(posedge clk) disable iff (!rst_n)
        xfer.sp_to_mar |=> (mar == $past(sp))); // R9

endmodule

// File: rtl/icyc_alu.sv
// Accumulator, result flags and mode bits. Executes load, add, and and
// compare on the operand in MBR, and applies enable/supervisor changes.
// Assumes the operand is already in MBR when alu_go is raised.
module icyc_alu
    import icyc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  exec_t         exe,
    input  logic [3:0]    op,
    input  logic [DW-1:0] mbr,
    output logic [DW-1:0] ac,
    output status_t       status
);

    logic [DW:0]   sum;
    logic [DW-1:0] conj;
    logic          f_sign, f_zero, f_carry, f_eq, f_ovf;
    logic          m_ie, m_sup;

    // Operand combinations.
    always_comb begin
        sum  = {1'b0, ac} + {1'b0, mbr};
        conj = ac & mbr;
    end

    // Accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) ac <= '0;
        else if (exe.alu_go) begin
            case (op)
                OP_LDA:  ac <= mbr;
                OP_ADD:  ac <= sum[DW-1:0];
                OP_AND:  ac <= conj;
                default: ac <= ac;
            endcase
        end
    end

    // Result flags; each operation touches only its own flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_sign <= 1'b0; f_zero <= 1'b0; f_carry <= 1'b0;
            f_eq   <= 1'b0; f_ovf  <= 1'b0;
        end else if (exe.alu_go) begin
            case (op)
                OP_LDA: begin
                    f_sign <= mbr[DW-1];
                    f_zero <= (mbr == '0);
                end
                OP_ADD: begin
                    f_sign  <= sum[DW-1];
                    f_zero  <= (sum[DW-1:0] == '0);
                    f_carry <= sum[DW];
                    f_ovf   <= (ac[DW-1] == mbr[DW-1]) && (sum[DW-1] != ac[DW-1]);
                end
                OP_AND: begin
                    f_sign <= conj[DW-1];
                    f_zero <= (conj == '0);
                end
                OP_CMP:  f_eq <= (ac == mbr);
                default: f_eq <= f_eq;
            endcase
        end
    end

    // Mode bits: reset and interrupt entry go supervisor with interrupts off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_ie  <= 1'b0;
            m_sup <= 1'b1;
        end else begin
            if (exe.ie_set)       m_ie <= 1'b1;
            else if (exe.ie_clr)  m_ie <= 1'b0;
            if (exe.sup_set)      m_sup <= 1'b1;
            else if (exe.sup_clr) m_sup <= 1'b0;
        end
    end

    // Assemble the status word.
    always_comb begin
        status.sup   = m_sup;
        status.ie    = m_ie;
        status.ovf   = f_ovf;
        status.eq    = f_eq;
        status.carry = f_carry;
        status.zero  = f_zero;
        status.sign  = f_sign;
    end

    AST_CMP_KEEPS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        (exe.alu_go && op == OP_CMP) |=> $stable(ac)); // R7
    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (exe.alu_go && op == OP_LDA) |=> (status.zero == (ac == '0) && status.sign == ac[DW-1])); // R6

endmodule

// File: rtl/icyc_ctrl.sv
// Top of the instruction cycle controller. Joins the sequencer, the
// address/instruction registers and the accumulator. Memory address
// and write data come straight from MAR and MBR. Assumes a synchronous
// memory with one cycle of read latency and AW <= DW-5.
module icyc_ctrl
    import icyc_pkg::*;
#(
    parameter int DW        = 16,
    parameter int AW        = 11,
    parameter int STACK_TOP = 'h7FF,
    parameter int HANDLER   = 'h040
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [6:0]    status
);

    localparam int OP_HI   = DW - 1;
    localparam int OP_LO   = DW - 4;
    localparam int IND_BIT = DW - 5;

    state_e        state;
    xfer_t         xfer;
    exec_t         exe;
    logic [AW-1:0] pc;
    logic [AW-1:0] mar;
    logic [DW-1:0] mbr;
    logic [DW-1:0] ir;
    logic [DW-1:0] ac;
    status_t       st;
    logic          mem_rd;
    logic          mem_wr;

    icyc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_op     (ir[OP_HI:OP_LO]),
        .mbr_ind   (mbr[IND_BIT]),
        .flag_zero (st.zero),
        .flag_sign (st.sign),
        .ie        (st.ie),
        .irq       (irq),
        .state     (state),
        .xfer      (xfer),
        .exe       (exe),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    icyc_regs #(
        .DW        (DW),
        .AW        (AW),
        .STACK_TOP (STACK_TOP),
        .HANDLER   (HANDLER)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .mem_rdata (mem_rdata),
        .ac        (ac),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir)
    );

    icyc_alu #(
        .DW (DW)
    ) u_alu (
        .clk    (clk),
        .rst_n  (rst_n),
        .exe    (exe),
        .op     (ir[OP_HI:OP_LO]),
        .mbr    (mbr),
        .ac     (ac),
        .status (st)
    );

    // Memory side: address and data straight from MAR and MBR.
    always_comb begin
        mem_addr  = mar;
        mem_wdata = mbr;
        mem_re    = mem_rd;
        mem_we    = mem_wr;
        status    = st;
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R12
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F0) |=> (mem_addr == $past(pc) && pc == AW'($past(pc) + AW'(1)))); // R2
    AST_IND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_I0) |-> ir[IND_BIT]); // R4
    AST_INT_SAVES_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_N2) |-> (mem_we && mem_wdata == DW'(pc))); // R9
    AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_N0) |-> (st.ie && $past(irq))); // R10
    AST_INT_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_N3) |=> (!st.ie && st.sup && pc == AW'(HANDLER))); // R11

endmodule

// File: tb/sim_icyc_ctrl.sv
module sim_icyc_ctrl;

    localparam int DW        = 16;
    localparam int AW        = 11;
    localparam int STACK_TOP = 'h7FF;
    localparam int HANDLER   = 'h040;
    localparam int DEPTH     = 1 << AW;
    localparam int WD_LIMIT  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq = 1'b0;
    logic [DW-1:0] mem_rdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_re;
    logic          mem_we;
    logic [DW-1:0] mem_wdata;
    logic [6:0]    status;

    logic [DW-1:0] mem [0:DEPTH-1];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int wr_seen = 0;
    int rd_n = 0;
    int rd_cyc [0:2];
    logic [AW-1:0] rd_addr [0:2];
    logic overlap = 1'b0;
    logic finished = 1'b0;

    logic [AW+DW-1:0] exp_q [$];
    string            tag_q [$];

    always #4 clk = ~clk;  // 8 ns period

    icyc_ctrl #(
        .DW(DW), .AW(AW), .STACK_TOP(STACK_TOP), .HANDLER(HANDLER)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .status(status)
    );

    // Synchronous memory, one cycle read latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input logic ind, input int a);
        return {op, ind, AW'(a)};
    endfunction

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_wr(input int a, input int d, input string req);
        exp_q.push_back({AW'(a), DW'(d)});
        tag_q.push_back(req);
    endtask

    // Monitor: pops the scoreboard on every write and records early reads.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_re && mem_we) overlap <= 1'b1;
            if (mem_re && rd_n < 3) begin
                rd_addr[rd_n] = mem_addr;
                rd_cyc[rd_n]  = cyc;
                rd_n++;
            end
            if (mem_we) begin
                wr_seen++;
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected write actual=%0h:%0h expected=none",
                             mem_addr, mem_wdata);
                end else begin
                    logic [AW+DW-1:0] item;
                    string t;
                    item = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (item != {mem_addr, mem_wdata}) begin
                        n_fail++;
                        $display("FAIL %s write actual=%0h:%0h expected=%0h:%0h", t,
                                 mem_addr, mem_wdata, item[AW+DW-1:DW], item[DW-1:0]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (!finished && cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=<%0d", cyc, WD_LIMIT);
            report();
        end
    end

    task automatic start(input logic irq_lvl);
        rst_n = 1'b0;
        irq = irq_lvl;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", status, 'h40, "status in reset");
        rd_n = 0;
        wr_seen = 0;
        rst_n = 1'b1;
    endtask

    task automatic clear_mem;
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    endtask

    task automatic drain(input string req);
        check(req, exp_q.size(), 0, "writes still expected");
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        // Program A: operand, indirect, flags, branches; irq high, IE clear (R10)
        clear_mem();
        mem[0]  = ins(4'h1, 0, 'h100);   // LDA
        mem[1]  = ins(4'h3, 0, 'h101);   // ADD
        mem[2]  = ins(4'h2, 0, 'h200);   // STA
        mem[3]  = ins(4'h3, 0, 'h102);   // ADD
        mem[4]  = ins(4'h2, 1, 'h103);   // STA indirect
        mem[5]  = ins(4'h7, 0, 'h008);   // JZ taken
        mem[6]  = ins(4'h2, 0, 'h2FF);   // skipped
        mem[8]  = ins(4'h1, 0, 'h104);   // LDA
        mem[9]  = ins(4'h4, 0, 'h105);   // AND
        mem[10] = ins(4'h5, 0, 'h104);   // CMP
        mem[11] = ins(4'h2, 0, 'h202);   // STA
        mem[12] = ins(4'h8, 0, 'h006);   // JN not taken
        mem[13] = ins(4'h6, 0, 'h00D);   // JMP self
        mem['h100] = 'h7FFF;
        mem['h101] = 'h0001;
        mem['h102] = 'h8000;
        mem['h103] = 'hF201;             // pointer, low 11 bits 0x201
        mem['h104] = 'h00F0;
        mem['h105] = 'h0FF0;
        expect_wr('h200, 'h8000, "R6");
        expect_wr('h201, 'h0000, "R4");
        expect_wr('h202, 'h00F0, "R8");
        start(1'b1);
        repeat (300) @(negedge clk);
        check("R1", rd_addr[0], 0, "first fetch address");
        check("R3", rd_addr[1], 'h100, "operand read address");
        check("R2", rd_addr[2], 1, "second fetch address");
        check("R3", rd_cyc[1] - rd_cyc[0], 4, "fetch-to-operand read gap");
        check("R2", rd_cyc[2] - rd_cyc[0], 8, "fetch-to-fetch gap for load");
        check("R6", status, 'h5C, "status after program A");
        check("R7", int'(status[3]), 1, "equal bit after compare");
        drain("R8");

        // Program B: EI with irq pending enters at once; handler leaves supervisor
        clear_mem();
        mem[0]      = ins(4'h9, 0, 0);       // EI
        mem['h40]   = ins(4'h2, 0, 'h201);   // STA
        mem['h41]   = ins(4'hB, 0, 0);       // USR
        mem['h42]   = ins(4'h6, 0, 'h042);   // JMP self
        expect_wr('h7FF, 'h0001, "R9");
        expect_wr('h201, 'h0000, "R9");
        start(1'b1);
        repeat (150) @(negedge clk);
        check("R11", status, 'h00, "status after handler with leave-supervisor");
        drain("R9");

        // Program C: two nested entries, stack pointer steps down
        clear_mem();
        mem[0]      = ins(4'h9, 0, 0);       // EI
        mem[1]      = ins(4'h1, 0, 'h100);   // LDA
        mem[2]      = ins(4'h6, 0, 'h002);   // JMP self
        mem['h40]   = ins(4'h2, 0, 'h201);   // STA
        mem['h41]   = ins(4'h9, 0, 0);       // EI
        mem['h42]   = ins(4'h6, 0, 'h042);   // JMP self
        mem['h100]  = 'h1234;
        expect_wr('h7FF, 'h0002, "R9");
        expect_wr('h201, 'h1234, "R5");
        expect_wr('h7FE, 'h0042, "R9");
        expect_wr('h201, 'h1234, "R5");
        start(1'b0);
        repeat (60) @(negedge clk);
        check("R11", status, 'h60, "status after enable");
        irq = 1'b1;
        wait (wr_seen >= 3);
        @(negedge clk);
        irq = 1'b0;
        repeat (150) @(negedge clk);
        check("R11", status, 'h60, "status after second handler enable");
        drain("R9");

        // Program D: disable before irq rises, so irq is ignored
        clear_mem();
        mem[0] = ins(4'h9, 0, 0);            // EI
        mem[1] = ins(4'hA, 0, 0);            // DI
        mem[2] = ins(4'h6, 0, 'h002);        // JMP self
        start(1'b0);
        repeat (40) @(negedge clk);
        irq = 1'b1;
        repeat (100) @(negedge clk);
        check("R10", status, 'h40, "status with irq while disabled");
        drain("R10");

        check("R12", int'(overlap), 0, "read and write strobe overlap");
        finished = 1'b1;
        report();
    end

endmodule